// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream on one output line. Software writes a character into a holding register. When the shift stage is free, the character moves across and goes out as one frame: a low start bit, the data bits least significant first, an optional parity bit, and a high stop period. Because the holding register and the shift stage are separate, the next character can be written while the current one is still on the line. When the holding register is already full at the end of a stop period, the next frame starts with no idle gap.

Bit timing comes from a single-cycle enable that pulses sixteen times per bit. Frame settings are data length, parity mode and stop length, and they are captured when a character enters the shift stage. Two flags report whether the holding register is free and whether the shift stage is idle. A break control holds the line low without disturbing the shift stage's progress.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever the shift stage is idle with break released, `txd` is 1 and both `thr_empty` and `tsr_empty` are 1.
- R2: A frame is a start bit (0), then the data bits least significant first, then the parity bit when enabled, then a stop period at 1. Each start, data and parity bit lasts exactly 16 `baud_tick` pulses.
- R3: `cfg_len` selects the data length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Unused upper bits of `wr_data` are not sent.
- R4: `cfg_par` selects parity: 2'b01 is odd (data plus parity holds an odd number of ones), 2'b10 is even, and 2'b00 or 2'b11 sends no parity bit.
- R5: The stop period lasts 16 ticks when `cfg_stop2` is 0. When it is 1, the period lasts 24 ticks with a 5-bit length and 32 ticks with any other length.
- R6: Bit timing advances only on cycles where `baud_tick` is 1.
- R7: A write clears `thr_empty` from the next cycle. `thr_empty` sets again in the cycle after the character moves into the shift stage. That move happens one cycle after a write into an idle stage, or on the tick that ends a stop period when a character is waiting.
- R8: `tsr_empty` is 0 from the cycle after a character is taken until the last stop tick completes. When a character is waiting at that point, the next start bit follows at once and `tsr_empty` stays 0.
- R9: A write while the holding register is full and the shift stage is busy replaces the held character. The replaced character is never sent.
- R10: While `brk` is 1, `txd` is 0. The frame in progress keeps its timing and ends at the same tick as without break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | Enable pulse, sixteen per bit time |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| cfg_len | input | 2 | Data length select |
| cfg_par | input | 2 | Parity mode select |
| cfg_stop2 | input | 1 | Long stop period select |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output line |
| thr_empty | output | 1 | Holding register free |
| tsr_empty | output | 1 | Shift stage idle |

## Verification
A write into the holding register can land in the same cycle that the register hands its previous content to the shift stage. The bench provokes this in two ways: it writes two characters on consecutive cycles into an idle transmitter, and it fires random writes while frames are running. A line monitor then checks that both characters go out in order and that `thr_empty` stays low after the handover. The bench also separates this case from a true overwrite during a busy frame, where the held character must be dropped. It checks that case against its own model of the character queue.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DW      = 8;
    localparam int OVS_DEF = 16;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_OFF  = 2'b11
    } par_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } st_e;

    typedef struct packed {
        logic [1:0] len;
        par_e       par;
        logic       stop_long;
    } cfg_t;

    function automatic logic [3:0] nbits(logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic [DW-1:0] len_mask(logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

    function automatic logic par_on(par_e p);
        return (p == PAR_ODD) || (p == PAR_EVEN);
    endfunction

    function automatic logic par_bit(logic [DW-1:0] d, cfg_t c);
        return (^(d & len_mask(c.len))) ^ (c.par == PAR_ODD);
    endfunction

    function automatic int unsigned stop_ticks(int unsigned ovs, cfg_t c);
        if (!c.stop_long) return ovs;
        if (c.len == 2'b00) return ovs + ovs / 2;
        return 2 * ovs;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr_en) begin
                full <= 1'b1;
                data <= wr_data;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    AST_TAKE_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        take |-> full); // R7
    AST_TAKE_FREES: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_en) |=> !full); // R7

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int OVS = OVS_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  cfg_t          cfg_in,
    output logic          take,
    output logic          line,
    output logic          busy
);

    localparam int CW = $clog2(2 * OVS + 1);

    st_e           st;
    logic [CW-1:0] tcnt;
    logic [2:0]    bidx;
    logic [DW-1:0] sh;
    logic          pb;
    cfg_t          cfg;
    logic [CW-1:0] lim;
    logic          bit_end;

    always_comb begin
        lim     = (st == S_STOP) ? CW'(stop_ticks(OVS, cfg)) : CW'(OVS);
        bit_end = tick && (tcnt == lim - 1'b1);
        take    = hold_full && ((st == S_IDLE) || (st == S_STOP && bit_end));
        busy    = (st != S_IDLE);
        case (st)
            S_START: line = 1'b0;
            S_DATA:  line = sh[0];
            S_PAR:   line = pb;
            default: line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            tcnt <= '0;
            bidx <= '0;
            sh   <= '0;
            pb   <= 1'b0;
            cfg  <= '0;
        end else if (take) begin
            st   <= S_START;
            tcnt <= '0;
            bidx <= '0;
            sh   <= hold_data;
            cfg  <= cfg_in;
            pb   <= par_bit(hold_data, cfg_in);
        end else if (st != S_IDLE) begin
            if (bit_end) begin
                tcnt <= '0;
                case (st)
                    S_START: st <= S_DATA;
                    S_DATA: begin
                        sh <= sh >> 1;
                        if ({1'b0, bidx} == nbits(cfg.len) - 4'd1)
                            st <= par_on(cfg.par) ? S_PAR : S_STOP;
                        else
                            bidx <= bidx + 3'd1;
                    end
                    S_PAR:   st <= S_STOP;
                    default: st <= S_IDLE;
                endcase
            end else if (tick) begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    AST_TCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        tcnt < CW'(2 * OVS)); // R5
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !take && busy) |=> $stable(tcnt)); // R6
    AST_BIDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == S_DATA) |-> ({1'b0, bidx} < nbits(cfg.len))); // R3

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int OVS = OVS_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_stop2,
    input  logic       brk,
    output logic       txd,
    output logic       thr_empty,
    output logic       tsr_empty
);

    cfg_t          cfg;
    logic          take;
    logic          hold_full;
    logic [DW-1:0] hold_data;
    logic          line;
    logic          busy;

    always_comb begin
        cfg.len       = cfg_len;
        cfg.par       = par_e'(cfg_par);
        cfg.stop_long = cfg_stop2;
    end

    sertx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_shift #(.OVS(OVS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cfg_in    (cfg),
        .take      (take),
        .line      (line),
        .busy      (busy)
    );

    assign txd       = brk ? 1'b0 : line;
    assign thr_empty = !hold_full;
    assign tsr_empty = !busy;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!busy && !brk) |-> txd); // R1
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        take |=> busy); // R8

endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;

    localparam int OVS = 16;

    typedef struct {
        logic [7:0] d;
        logic [1:0] len;
        logic [1:0] par;
        logic       sl;
    } ent_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] cfg_len = '0;
    logic [1:0] cfg_par = '0;
    logic       cfg_stop2 = 1'b0;
    logic       brk = 1'b0;
    logic       txd, thr_empty, tsr_empty;

    int  tests = 0;
    int  fails = 0;
    bit  done = 0;
    bit  mon_en = 0;
    bit  tick_rand = 0;
    bit  tick_q = 0;
    bit  wr_q = 0;

    ent_t q[$];
    bit   act = 0;
    int   k, nb, sticks;
    logic [11:0] expb, gotb;

    always #4 clk = ~clk;

    sertx_top #(.OVS(OVS)) dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_stop2(cfg_stop2), .brk(brk), .txd(txd),
        .thr_empty(thr_empty), .tsr_empty(tsr_empty)
    );

    task automatic chk(input bit ok, input string tag, input int actv, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actv, expv);
        end
    endtask

    function automatic int f_nbits(logic [1:0] len);
        return 5 + int'(len);
    endfunction

    function automatic int f_stop(logic [1:0] len, logic sl);
        if (!sl) return OVS;
        return (len == 2'b00) ? (OVS * 3) / 2 : 2 * OVS;
    endfunction

    always @(posedge clk) begin
        tick_q <= baud_tick;
        wr_q   <= wr_en;
    end

    initial begin
        forever begin
            @(negedge clk);
            baud_tick = tick_rand ? 1'($urandom % 2) : 1'b1;
        end
    end

    task automatic start_frame();
        ent_t e;
        int   n, ones;
        if (q.size() == 0) begin
            chk(0, "R2 unexpected start bit", 0, 1);
            act = 0;
            return;
        end
        e = q.pop_front();
        n = f_nbits(e.len);
        expb = '0;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            expb[1+i] = e.d[i];
            ones += int'(e.d[i]);
        end
        nb = 1 + n;
        if (e.par == 2'b01 || e.par == 2'b10) begin
            expb[nb] = (e.par == 2'b01) ? ~ones[0] : ones[0];
            nb++;
        end
        sticks = f_stop(e.len, e.sl);
        chk(thr_empty == !wr_q, "R7 thr_empty after handover", int'(thr_empty), int'(!wr_q));
        gotb = '1;
        k = 0;
        act = 1;
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (act) begin
                if (tick_q) begin
                    k++;
                    if (k % OVS == OVS / 2 && k / OVS < nb) gotb[k / OVS] = txd;
                    if (k == OVS * nb + OVS / 2)
                        chk(txd == 1'b1, "R2 stop level", int'(txd), 1);
                    if (k == OVS * nb + sticks - 1)
                        chk(txd && !tsr_empty, "R5 stop still running", int'(tsr_empty), 0);
                    if (k == OVS * nb + sticks) begin
                        chk(gotb[11:0] == (expb | (12'hFFF << nb)) && (nb < 12 ? 1'b1 : 1'b1),
                            "R2/R3/R4 frame bits", int'(gotb), int'(expb | (12'hFFF << nb)));
                        if (!txd) start_frame();
                        else begin
                            chk(tsr_empty == 1'b1, "R8 shifter empty at stop end", int'(tsr_empty), 1);
                            act = 0;
                        end
                    end
                end
            end else if (!txd && !brk) begin
                start_frame();
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        ent_t e;
        e.d = d; e.len = cfg_len; e.par = cfg_par; e.sl = cfg_stop2;
        if (!thr_empty && !tsr_empty && q.size() > 0) q[q.size()-1] = e;
        else q.push_back(e);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(tsr_empty && thr_empty && !act)) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_thr();
        while (!thr_empty) @(negedge clk);
    endtask

    task automatic setcfg(input logic [1:0] l, input logic [1:0] p, input logic s);
        cfg_len = l; cfg_par = p; cfg_stop2 = s;
    endtask

    initial begin
        int busy_cnt;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd && thr_empty && tsr_empty, "R1 reset state",
            {29'd0, txd, thr_empty, tsr_empty}, 7);
        mon_en = 1;

        // R2 R3: 8 bits, no parity, one stop
        setcfg(2'b11, 2'b00, 1'b0);
        wr(8'hA5);
        wait_idle();
        chk(q.size() == 0, "R2 frame consumed", q.size(), 0);

        // R5: 1.5 stop with 5 bits, even parity; upper bits masked (R3)
        setcfg(2'b00, 2'b10, 1'b1);
        wr(8'hF3);
        wait_idle();
        // R5: 2 stop with 6 bits, odd parity
        setcfg(2'b01, 2'b01, 1'b1);
        wr(8'h2C);
        wait_idle();

        // R7 R8: writes on consecutive cycles, one lands on the handover
        setcfg(2'b10, 2'b01, 1'b1);
        wr(8'h5A);
        wr(8'h33);
        chk(!thr_empty, "R7 second char held", int'(thr_empty), 0);
        wait_idle();

        // R9: overwrite of a held character while busy
        setcfg(2'b11, 2'b10, 1'b0);
        wr(8'h11);
        wait_thr();
        wr(8'h22);
        chk(!thr_empty, "R7 held after write", int'(thr_empty), 0);
        wr(8'h44);
        wait_idle();
        chk(q.size() == 0, "R9 replaced char dropped", q.size(), 0);

        // R6: random tick gating with random settings and traffic
        tick_rand = 1;
        for (int it = 0; it < 40; it++) begin
            setcfg(2'($urandom), 2'($urandom), 1'($urandom));
            for (int c = 0; c < 1 + int'($urandom % 3); c++) begin
                wait_thr();
                repeat ($urandom % 12) @(negedge clk);
                wr(8'($urandom));
            end
            wait_idle();
        end
        tick_rand = 0;

        // R10: break on idle line and during a frame
        mon_en = 0;
        setcfg(2'b11, 2'b00, 1'b0);
        brk = 1'b1;
        @(negedge clk);
        chk(txd == 1'b0, "R10 break on idle", int'(txd), 0);
        brk = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R1 line back high", int'(txd), 1);
        wr_en = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        while (tsr_empty) @(negedge clk);
        busy_cnt = 0;
        while (!tsr_empty) begin
            brk = (busy_cnt >= 30 && busy_cnt < 80);
            busy_cnt++;
            @(negedge clk);
            if (brk) chk(txd == 1'b0, "R10 break forces low", int'(txd), 0);
        end
        brk = 1'b0;
        chk(busy_cnt == 10 * OVS, "R10 frame timing kept", busy_cnt, 10 * OVS);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule